// File: doc/BRIEF.md
# Change-of-Flow Trace Recorder

This block records recent control-flow history for a processor debug unit. It watches the retire stream. Each retired instruction reports its address and whether it is a change-of-flow. For a conditional change-of-flow it also reports whether the condition held, and it carries the target address. The history sits in a twelve-slot ring. Each slot holds a 16-bit address in bits 15:0 and a not-taken marker in bit 16.

When a change-of-flow is taken, the block stores the branch address and then the target address in two consecutive slots in one cycle. When a conditional change-of-flow is not taken, only the branch address is stored, with the marker bit set. Ordinary instructions store nothing, but the block remembers the last one that retired. On entry to debug mode, that remembered address is written as the newest slot. Recording stops while debug mode is active.

An external debug controller reads the history through one shared access. Each accepted access returns the slot at the read pointer and then moves the pointer on by one. The first read after debug entry returns the oldest slot. Each entry read is also loaded into a serial shifter, which emits the marker bit first and then the address, least significant bit first.

Top module: `cof_trace_buffer`

## Requirements
- R1: Synchronous active-high reset clears every slot to zero, clears both pointers, and drives rd_vld and ser_out low.
- R2: A retired change-of-flow that is taken writes two slots with bit 16 clear: the branch address at the write pointer, then the target address in the next slot. The write pointer advances by two. A change-of-flow with retire_cond low is always taken.
- R3: A retired conditional change-of-flow with retire_taken low writes only its own address, with bit 16 set, and the write pointer advances by one.
- R4: A retired instruction that is not a change-of-flow writes no slot, but its address becomes the last-executed address. On debug entry, that address is written to the slot at the write pointer with bit 16 clear.
- R5: After debug entry, the read pointer points to the slot just after the newest one. Successive reads therefore return slots from oldest to newest.
- R6: Each accepted read returns the slot at the read pointer and then advances the pointer by one, wrapping from 11 to 0. After twelve reads, the next read returns the same slot as the first.
- R7: While debug mode is held, retired instructions change neither the slots nor the last-executed address.
- R8: A read access is accepted only from the second cycle of debug mode onward. Outside that window, rd_vld stays low and the read pointer is unchanged.
- R9: rd_vld pulses high for exactly the cycle after an accepted access, and rd_data holds the returned slot in that cycle.
- R10: ser_load is a read access. Two cycles after it is accepted, ser_out shows bit 16 of the returned slot. Each ser_shift then moves ser_out to the next address bit, bit 0 first, for 17 bits in total.
- R11: The write pointer wraps from 11 to 0. A taken change-of-flow whose branch lands in slot 11 puts its target in slot 0, overwriting the oldest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_vld | input | 1 | An instruction retired this cycle |
| retire_pc | input | 16 | Address of the retired instruction |
| retire_cof | input | 1 | Retired instruction is a change-of-flow |
| retire_cond | input | 1 | The change-of-flow is conditional |
| retire_taken | input | 1 | Condition held (used when retire_cond is high) |
| retire_tgt | input | 16 | Target address of the change-of-flow |
| debug_mode | input | 1 | Processor is in debug mode |
| rd_req | input | 1 | Parallel read access |
| ser_load | input | 1 | Read access that also primes the serial output |
| ser_shift | input | 1 | Advance the serial output by one bit |
| rd_vld | output | 1 | Read data valid strobe |
| rd_data | output | 17 | Returned slot: marker in bit 16, address in 15:0 |
| ser_out | output | 1 | Serial output bit |

## Verification
The hardest case to reach from the ports is a taken change-of-flow whose branch lands in slot 11, so that its target wraps into slot 0. Reset followed by a debug entry leaves the write pointer odd. The stimulus then walks the pointer to slot 11 using a counted mix of taken pairs and single not-taken writes. A scoreboard model predicts every slot, so the oldest-first sweep after the next debug entry shows the wrap. Retires sent during debug mode, reads sent in the entry cycle and reads sent outside debug mode are each followed by a full sweep or a strobe check. These show that none of them moved the contents or the pointer.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
  // modular increment for a ring of arbitrary (even) length
  function automatic int unsigned ring_add(input int unsigned p, input int unsigned inc,
                                           input int unsigned depth);
    int unsigned s;
    s = p + inc;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/cof_trace_bank.sv
// One parity half of the ring: single write port, registered read port.
module cof_trace_bank #(
  parameter int ROWS    = 6,
  parameter int ROW_W   = 3,
  parameter int ENTRY_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ROW_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               re,
  input  logic [ROW_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cof_trace_ctrl.sv
// Capture decode, write/read pointer management and debug freeze.
module cof_trace_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int DEPTH   = 12,
  parameter int PTR_W   = 4,
  parameter int ROW_W   = 3,
  parameter int ENTRY_W = 17
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       retire_vld,
  input  logic [ADDR_W-1:0]          retire_pc,
  input  logic                       retire_cof,
  input  logic                       retire_cond,
  input  logic                       retire_taken,
  input  logic [ADDR_W-1:0]          retire_tgt,
  input  logic                       debug_mode,
  input  logic                       acc_req,
  output logic [1:0]                 lane_we,
  output logic [1:0][ROW_W-1:0]      lane_row,
  output logic [1:0][ENTRY_W-1:0]    lane_data,
  output logic [PTR_W-1:0]           wr_ptr,
  output logic [PTR_W-1:0]           rd_ptr,
  output logic                       dbg_q,
  output logic                       rd_fire
);
  import cof_trace_pkg::*;

  logic [ADDR_W-1:0]  last_pc;
  logic               capture, dbg_entry, taken;
  logic [PTR_W-1:0]   slot_a, slot_b, wr_next, rd_next;
  logic               we_a, we_b;
  logic [ENTRY_W-1:0] data_a, data_b;
  logic [1:0]         step;

  assign capture   = retire_vld && !debug_mode;
  assign dbg_entry = debug_mode && !dbg_q;
  assign taken     = !retire_cond || retire_taken;
  assign rd_fire   = acc_req && debug_mode && dbg_q;

  assign slot_a  = wr_ptr;
  assign slot_b  = PTR_W'(ring_add(32'(wr_ptr), 1, DEPTH));
  assign wr_next = PTR_W'(ring_add(32'(wr_ptr), 32'(step), DEPTH));
  assign rd_next = PTR_W'(ring_add(32'(rd_ptr), 1, DEPTH));

  // what to write this cycle, in slot order
  always_comb begin
    we_a   = 1'b0;
    we_b   = 1'b0;
    data_a = '0;
    data_b = '0;
    step   = 2'd0;
    if (dbg_entry) begin
      we_a   = 1'b1;
      data_a = {1'b0, last_pc};
      step   = 2'd1;
    end else if (capture && retire_cof) begin
      we_a = 1'b1;
      if (taken) begin
        data_a = {1'b0, retire_pc};
        we_b   = 1'b1;
        data_b = {1'b0, retire_tgt};
        step   = 2'd2;
      end else begin
        data_a = {1'b1, retire_pc};
        step   = 2'd1;
      end
    end
  end

  // consecutive slots always fall in opposite parity banks
  always_comb begin
    lane_we   = '0;
    lane_row  = '0;
    lane_data = '0;
    if (we_a) begin
      lane_we[slot_a[0]]   = 1'b1;
      lane_row[slot_a[0]]  = slot_a[PTR_W-1:1];
      lane_data[slot_a[0]] = data_a;
    end
    if (we_b) begin
      lane_we[slot_b[0]]   = 1'b1;
      lane_row[slot_b[0]]  = slot_b[PTR_W-1:1];
      lane_data[slot_b[0]] = data_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      dbg_q   <= 1'b0;
      last_pc <= '0;
    end else begin
      dbg_q  <= debug_mode;
      wr_ptr <= wr_next;
      if (capture) last_pc <= retire_pc;
      if (dbg_entry) rd_ptr <= wr_next;
      else if (rd_fire) rd_ptr <= rd_next;
    end
  end
endmodule

// File: rtl/cof_trace_shifter.sv
// Serial output: marker bit first, then address LSB first.
module cof_trace_shifter #(
  parameter int ADDR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [ADDR_W:0] din,
  input  logic            shift,
  output logic            sout
);
  logic [ADDR_W:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else if (load) sh <= {din[ADDR_W-1:0], din[ADDR_W]};
    else if (shift) sh <= {1'b0, sh[ADDR_W:1]};
  end

  assign sout = sh[0];
endmodule

// File: rtl/cof_trace_buffer.sv
module cof_trace_buffer #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_vld,
  input  logic [ADDR_W-1:0] retire_pc,
  input  logic              retire_cof,
  input  logic              retire_cond,
  input  logic              retire_taken,
  input  logic [ADDR_W-1:0] retire_tgt,
  input  logic              debug_mode,
  input  logic              rd_req,
  input  logic              ser_load,
  input  logic              ser_shift,
  output logic              rd_vld,
  output logic [ADDR_W:0]   rd_data,
  output logic              ser_out
);
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int ROWS    = DEPTH / 2;
  localparam int ROW_W   = PTR_W - 1;
  localparam int ENTRY_W = ADDR_W + 1;

  logic [1:0]                 lane_we;
  logic [1:0][ROW_W-1:0]      lane_row;
  logic [1:0][ENTRY_W-1:0]    lane_data;
  logic [1:0][ENTRY_W-1:0]    bank_q;
  logic [PTR_W-1:0]           wr_ptr, rd_ptr;
  logic                       dbg_q, rd_fire, sel_q;

  cof_trace_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .ROW_W(ROW_W), .ENTRY_W(ENTRY_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .retire_vld(retire_vld), .retire_pc(retire_pc), .retire_cof(retire_cof),
    .retire_cond(retire_cond), .retire_taken(retire_taken), .retire_tgt(retire_tgt),
    .debug_mode(debug_mode), .acc_req(rd_req || ser_load),
    .lane_we(lane_we), .lane_row(lane_row), .lane_data(lane_data),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .dbg_q(dbg_q), .rd_fire(rd_fire)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    cof_trace_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .ENTRY_W(ENTRY_W)) bank_i (
      .clk(clk), .rst(rst),
      .we(lane_we[b]), .waddr(lane_row[b]), .wdata(lane_data[b]),
      .re(rd_fire), .raddr(rd_ptr[PTR_W-1:1]), .rdata(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      rd_vld <= rd_fire;
      if (rd_fire) sel_q <= rd_ptr[0];
    end
  end

  assign rd_data = bank_q[sel_q];

  cof_trace_shifter #(.ADDR_W(ADDR_W)) shift_i (
    .clk(clk), .rst(rst), .load(rd_vld), .din(rd_data),
    .shift(ser_shift), .sout(ser_out)
  );
endmodule

// File: rtl/cof_trace_buffer_chk.sv
module cof_trace_buffer_chk #(
  parameter int DEPTH = 12,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             retire_vld,
  input logic             retire_cof,
  input logic             retire_cond,
  input logic             retire_taken,
  input logic             debug_mode,
  input logic             rd_vld,
  input logic             rd_fire,
  input logic             dbg_q,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr
);
  import cof_trace_pkg::*;

  a_r2_taken_two_slots: assert property (@(posedge clk) disable iff (rst)
    (retire_vld && retire_cof && (!retire_cond || retire_taken) && !debug_mode)
    |=> wr_ptr == PTR_W'(ring_add(32'($past(wr_ptr)), 2, DEPTH)));

  a_r3_not_taken_one_slot: assert property (@(posedge clk) disable iff (rst)
    (retire_vld && retire_cof && retire_cond && !retire_taken && !debug_mode)
    |=> wr_ptr == PTR_W'(ring_add(32'($past(wr_ptr)), 1, DEPTH)));

  a_r5_entry_points_oldest: assert property (@(posedge clk) disable iff (rst)
    (debug_mode && !dbg_q) |=> rd_ptr == wr_ptr);

  a_r6_read_advances: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> rd_ptr == PTR_W'(ring_add(32'($past(rd_ptr)), 1, DEPTH)));

  a_r7_frozen_in_debug: assert property (@(posedge clk) disable iff (rst)
    (debug_mode && dbg_q) |=> $stable(wr_ptr));

  a_r8_reads_only_in_debug: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(debug_mode));

  a_r9_strobe_follows_access: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(rd_fire));

  a_r11_ptrs_in_range: assert property (@(posedge clk) disable iff (rst)
    (32'(wr_ptr) < DEPTH) && (32'(rd_ptr) < DEPTH));
endmodule

bind cof_trace_buffer cof_trace_buffer_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .retire_vld(retire_vld), .retire_cof(retire_cof),
  .retire_cond(retire_cond), .retire_taken(retire_taken), .debug_mode(debug_mode),
  .rd_vld(rd_vld), .rd_fire(rd_fire), .dbg_q(dbg_q), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/cof_trace_buffer_tb_top.sv
module cof_trace_buffer_tb_top;
  localparam int D = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_vld = 0, retire_cof = 0, retire_cond = 0, retire_taken = 0;
  logic [15:0] retire_pc = '0, retire_tgt = '0;
  logic        debug_mode = 0, rd_req = 0, ser_load = 0, ser_shift = 0;
  logic        rd_vld, ser_out;
  logic [16:0] rd_data;

  int n_run = 0, n_fail = 0;

  // bench model of the ring
  logic [16:0] m_mem [D];
  int          m_w = 0, m_r = 0;
  logic [15:0] m_last = '0;
  logic [16:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  cof_trace_buffer dut_i (
    .clk(clk), .rst(rst), .retire_vld(retire_vld), .retire_pc(retire_pc),
    .retire_cof(retire_cof), .retire_cond(retire_cond), .retire_taken(retire_taken),
    .retire_tgt(retire_tgt), .debug_mode(debug_mode), .rd_req(rd_req),
    .ser_load(ser_load), .ser_shift(ser_shift), .rd_vld(rd_vld),
    .rd_data(rd_data), .ser_out(ser_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected slot whenever the strobe shows up
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (exp_q.size() == 0) chk("R9 unexpected strobe", 1, 0);
      else chk(tag_q.pop_front(), 32'(rd_data), 32'(exp_q.pop_front()));
    end
  end

  task automatic retire(input logic [15:0] pc, input logic cof, input logic cond,
                        input logic tk, input logic [15:0] tgt);
    if (!debug_mode) begin
      if (cof) begin
        if (!cond || tk) begin
          m_mem[m_w] = {1'b0, pc};
          m_mem[(m_w + 1) % D] = {1'b0, tgt};
          m_w = (m_w + 2) % D;
        end else begin
          m_mem[m_w] = {1'b1, pc};
          m_w = (m_w + 1) % D;
        end
      end
      m_last = pc;
    end
    retire_vld = 1; retire_pc = pc; retire_cof = cof; retire_cond = cond;
    retire_taken = tk; retire_tgt = tgt;
    @(negedge clk);
    retire_vld = 0; retire_cof = 0;
  endtask

  task automatic enter_debug();
    m_mem[m_w] = {1'b0, m_last};
    m_w = (m_w + 1) % D;
    m_r = m_w;
    debug_mode = 1;
    @(negedge clk);
  endtask

  task automatic read_one(input string tag);
    exp_q.push_back(m_mem[m_r]);
    tag_q.push_back(tag);
    m_r = (m_r + 1) % D;
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic sweep(input int n, input string tag);
    for (int i = 0; i < n; i++) read_one(tag);
    @(negedge clk);
  endtask

  task automatic ser_read(input string tag);
    logic [16:0] e;
    e = m_mem[m_r];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    m_r = (m_r + 1) % D;
    ser_load = 1;
    @(negedge clk);
    ser_load = 0;
    @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      chk(tag, 32'(ser_out), 32'((i == 0) ? e[16] : e[i-1]));
      if (i < 16) begin
        ser_shift = 1;
        @(negedge clk);
      end
    end
    ser_shift = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports, then all slots zero
    chk("R1 rd_vld", 32'(rd_vld), 0);
    chk("R1 ser_out", 32'(ser_out), 0);
    enter_debug();
    sweep(D, "R1 cleared slots");
    debug_mode = 0;
    @(negedge clk);

    // R2: taken branches, write pointer 1 -> 11; R4 plain instruction
    for (int i = 0; i < 5; i++) retire(16'h1000 + 16'(i * 16), 1, 0, 0, 16'h2000 + 16'(i * 16));
    retire(16'h0100, 0, 0, 0, 16'h0);
    enter_debug();
    sweep(D, "R2 R5 oldest-first");
    sweep(1, "R6 thirteenth read repeats first");
    debug_mode = 0;
    @(negedge clk);

    // R3 not-taken, taken conditional, then R11 branch landing on slot 11
    retire(16'h3000, 1, 1, 0, 16'h3F00);
    retire(16'h3004, 1, 1, 0, 16'h3F04);
    retire(16'h3008, 1, 1, 0, 16'h3F08);
    retire(16'h300C, 1, 1, 1, 16'h4000);
    for (int i = 0; i < 3; i++) retire(16'h5000 + 16'(i), 1, 0, 0, 16'h6000 + 16'(i));
    retire(16'h7000, 1, 0, 0, 16'h7100);
    retire(16'h3333, 0, 0, 0, 16'h0);
    enter_debug();
    // R7: retires during debug are ignored
    retire(16'hAAAA, 1, 0, 0, 16'hBBBB);
    retire(16'hCCCC, 1, 1, 0, 16'hDDDD);
    retire(16'hEEEE, 0, 0, 0, 16'h0);
    sweep(D, "R3 R4 R7 R11 sweep");

    // R10: serial output of a not-taken slot and of a plain slot
    ser_read("R10 serial");
    ser_read("R10 serial");

    // R9: strobe timing for a single access
    exp_q.push_back(m_mem[m_r]);
    tag_q.push_back("R9 data");
    m_r = (m_r + 1) % D;
    rd_req = 1;
    chk("R9 no strobe before edge", 32'(rd_vld), 0);
    @(negedge clk);
    rd_req = 0;
    chk("R9 strobe", 32'(rd_vld), 1);
    @(negedge clk);
    chk("R9 single pulse", 32'(rd_vld), 0);

    // R8: reads outside debug mode are ignored
    debug_mode = 0;
    @(negedge clk);
    rd_req = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no strobe outside debug", 32'(rd_vld), 0);
    end
    rd_req = 0;
    // R8: read in the entry cycle is ignored; the sweep still starts at the oldest slot
    m_mem[m_w] = {1'b0, m_last};
    m_w = (m_w + 1) % D;
    m_r = m_w;
    debug_mode = 1;
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    chk("R8 no strobe in entry cycle", 32'(rd_vld), 0);
    sweep(D, "R8 pointer untouched");

    @(negedge clk);
    chk("R9 all expected reads seen", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule